// File: doc/BRIEF.md
# Operand Address Generator

This unit turns an addressing-mode code and the raw operand bytes of an instruction into the 16-bit address of that instruction's operand. Besides the two operand bytes it takes the two index registers, the program counter at the operand byte, and the address of the instruction that follows. One clock after a request, the address comes out of a register, with a strobe that marks it as usable. Memory access, opcode decoding and branch-condition evaluation belong to other blocks.

All sums wrap modulo 2^16 and no overflow indication is produced. Offsets added to an index register are taken as unsigned. Branch offsets are taken as two's complement and are measured from the address of the next instruction. Direct-page addresses always fall in page zero. A mode code outside the defined set produces address zero and leaves the strobe low.

The control is a three-state machine, re-evaluated on every clock. IDLE means no request was seen in the last cycle. ISSUE means the last request had a defined mode and the strobe is high. REJECT means the last request had an undefined mode: the strobe is low and the address is zero. The transitions are the same from every state. A request with a defined mode leads to ISSUE (transition "accept"). A request with an undefined mode leads to REJECT (transition "refuse"). No request leads to IDLE (transition "drop").

Top module: `agu_top`

## Requirements
- R1: While reset is asserted and after it is released, before any request, `ea` is 0x0000 and `ea_vld` is 0.
- R2: A request with a defined mode (codes 0 to 7) raises `ea_vld` in the cycle after the request edge. With no request, `ea_vld` is 0 in the cycle after.
- R3: Mode code 0 (immediate) gives `ea` = `pc_cur`, the address of the operand byte.
- R4: Mode code 1 (direct page) gives `ea` = {0x00, `op_b1`}, ignoring `op_b2`.
- R5: Mode code 2 (extended) gives `ea` = {`op_b1`, `op_b2`}, with the first byte as the most significant.
- R6: Mode codes 3 (X) and 4 (Y) give `ea` = index + zero-extended `op_b1`, modulo 2^16. Example: 0xA13F + 0x0A = 0xA149.
- R7: Mode codes 5 (X) and 6 (Y) give `ea` = the index register unchanged, ignoring both operand bytes.
- R8: Mode code 7 (relative) gives `ea` = `pc_next` + sign-extended `op_b1`, modulo 2^16. Example: 0x1002 with 0xFE gives 0x1000.
- R9: A request with a mode code from 8 to 15 gives `ea` = 0x0000 and `ea_vld` = 0 in the next cycle.
- R10: In a cycle with no request, `ea` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Address request |
| mode | input | 4 | Addressing-mode code |
| op_b1 | input | 8 | First operand byte |
| op_b2 | input | 8 | Second operand byte |
| idx_x | input | 16 | Index register X |
| idx_y | input | 16 | Index register Y |
| pc_cur | input | 16 | Address of the operand byte |
| pc_next | input | 16 | Address of the following instruction |
| ea | output | 16 | Effective address, registered |
| ea_vld | output | 1 | Effective address valid |

## Verification
The bench targets the cases where the width and the sign of the extension matter.

- **Unsigned index offset.** An index offset of 0xFF must add 255. A design that sign-extended it would land 256 bytes too low.
- **Backward and wrapping branches.** Branch offsets of 0xFE and 0x80 must move backwards. The 0x80 case also wraps below zero. A zero-extending design would jump forward instead.
- **Index wrap.** An index sum that crosses 0xFFFF must wrap to a small address. A design that kept a carry, or clamped the sum, would not.
- **Ignored operand bytes.** Direct-page and indirect requests are given non-zero bytes that must not affect the result. This catches a swapped byte order, or an offset added where none belongs.
- **Undefined codes and idle cycles.** An undefined code must give a zero address with the strobe low. An idle cycle must hold the address with the strobe low. This exposes a strobe left high, or a stale address leaking through.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        M_IMM   = 4'd0,
        M_DIR   = 4'd1,
        M_EXT   = 4'd2,
        M_IDX_X = 4'd3,
        M_IDX_Y = 4'd4,
        M_IND_X = 4'd5,
        M_IND_Y = 4'd6,
        M_REL   = 4'd7
    } mode_e;

    localparam logic [MODE_W-1:0] LAST_MODE = 4'd7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_REJECT = 2'd2
    } agu_state_e;
endpackage

// File: rtl/agu_offset_ext.sv
module agu_offset_ext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  off_in,
    input  logic             sign_en,
    output logic [OUT_W-1:0] off_out
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            logic fill;
            always_comb fill = sign_en & off_in[IN_W-1];
            always_comb off_out = {{PAD_W{fill}}, off_in};
        end else begin : g_nopad
            always_comb off_out = off_in[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/agu_calc.sv
module agu_calc
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W,
    parameter int MW = MODE_W
) (
    input  logic [MW-1:0] mode,
    input  logic [BW-1:0] op_b1,
    input  logic [BW-1:0] op_b2,
    input  logic [AW-1:0] idx_x,
    input  logic [AW-1:0] idx_y,
    input  logic [AW-1:0] pc_cur,
    input  logic [AW-1:0] pc_next,
    output logic [AW-1:0] addr,
    output logic          defined
);
    localparam int HI_W = AW - BW;

    logic [AW-1:0] uoff;
    logic [AW-1:0] soff;
    logic [AW-1:0] base_idx;

    agu_offset_ext #(.IN_W(BW), .OUT_W(AW)) u_uext (
        .off_in (op_b1),
        .sign_en(1'b0),
        .off_out(uoff)
    );

    agu_offset_ext #(.IN_W(BW), .OUT_W(AW)) u_sext (
        .off_in (op_b1),
        .sign_en(1'b1),
        .off_out(soff)
    );

    always_comb begin
        base_idx = idx_x;
        if (mode == M_IDX_Y || mode == M_IND_Y)
            base_idx = idx_y;
    end

    always_comb begin
        addr    = '0;
        defined = (mode <= LAST_MODE);
        unique case (mode)
            M_IMM:            addr = pc_cur;
            M_DIR:            addr = {{HI_W{1'b0}}, op_b1};
            M_EXT:            addr = {op_b1, op_b2};
            M_IDX_X, M_IDX_Y: addr = base_idx + uoff;
            M_IND_X, M_IND_Y: addr = base_idx;
            M_REL:            addr = pc_next + soff;
            default:          addr = '0;
        endcase
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [MODE_W-1:0] mode,
    input  logic [BYTE_W-1:0] op_b1,
    input  logic [BYTE_W-1:0] op_b2,
    input  logic [ADDR_W-1:0] idx_x,
    input  logic [ADDR_W-1:0] idx_y,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] pc_next,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_vld
);
    agu_state_e    state_q, state_d;
    logic [ADDR_W-1:0] calc_addr;
    logic          calc_def;
    logic [ADDR_W-1:0] ea_q;

    agu_calc #(.AW(ADDR_W), .BW(BYTE_W), .MW(MODE_W)) u_calc (
        .mode   (mode),
        .op_b1  (op_b1),
        .op_b2  (op_b2),
        .idx_x  (idx_x),
        .idx_y  (idx_y),
        .pc_cur (pc_cur),
        .pc_next(pc_next),
        .addr   (calc_addr),
        .defined(calc_def)
    );

    // next state: identical transitions from every state
    always_comb begin
        unique case ({req, calc_def})
            2'b11:   state_d = ST_ISSUE;   // accept
            2'b10:   state_d = ST_REJECT;  // refuse
            default: state_d = ST_IDLE;    // drop
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ea_q <= '0;
        else if (req)
            ea_q <= calc_def ? calc_addr : '0;
    end

    always_comb begin
        ea     = ea_q;
        ea_vld = 1'b0;
        unique case (state_q)
            ST_IDLE:   ea_vld = 1'b0;
            ST_ISSUE:  ea_vld = 1'b1;
            ST_REJECT: ea_vld = 1'b0;
            default:   ea_vld = 1'b0;
        endcase
    end

    assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode <= LAST_MODE) |=> ea_vld);
    assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ea_vld);
    assert_imm_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == M_IMM) |=> ea == $past(pc_cur));
    assert_dir_page0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == M_DIR) |=> ea[ADDR_W-1:BYTE_W] == '0);
    assert_ind_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == M_IND_X) |=> ea == $past(idx_x));
    assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode > LAST_MODE) |=> (ea == '0 && !ea_vld));
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(ea));
endmodule

// File: tb/agu_top_test.sv
module agu_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  op_b1 = '0;
    logic [7:0]  op_b2 = '0;
    logic [15:0] idx_x = '0;
    logic [15:0] idx_y = '0;
    logic [15:0] pc_cur = '0;
    logic [15:0] pc_next = '0;
    logic [15:0] ea;
    logic        ea_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    agu_top uut (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
        .op_b1(op_b1), .op_b2(op_b2), .idx_x(idx_x), .idx_y(idx_y),
        .pc_cur(pc_cur), .pc_next(pc_next), .ea(ea), .ea_vld(ea_vld)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request, check the registered result, then check an idle cycle holds it.
    task automatic run(string tag, logic [3:0] m, logic [7:0] b1, logic [7:0] b2,
                       logic [15:0] x, logic [15:0] y, logic [15:0] pc,
                       logic [15:0] pcn, logic [15:0] exp_ea, logic exp_v);
        @(negedge clk);
        req = 1'b1; mode = m; op_b1 = b1; op_b2 = b2;
        idx_x = x; idx_y = y; pc_cur = pc; pc_next = pcn;
        @(negedge clk);
        req = 1'b0; op_b1 = 8'hC3; op_b2 = 8'h3C; idx_x = 16'h5A5A;
        chk({tag, " ea"}, ea, exp_ea);
        chk({tag, " R2 valid"}, {15'd0, ea_vld}, {15'd0, exp_v});
        @(negedge clk);
        chk("R10 hold ea", ea, exp_ea);
        chk("R2 idle valid", {15'd0, ea_vld}, 16'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset ea", ea, 16'h0000);
        chk("R1 reset valid", {15'd0, ea_vld}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset ea", ea, 16'h0000);
        chk("R1 post-reset valid", {15'd0, ea_vld}, 16'd0);
    endtask

    task automatic t_imm();
        run("R3 imm", 4'd0, 8'h11, 8'h22, 16'h0, 16'h0, 16'hC801, 16'hC803, 16'hC801, 1'b1);
    endtask

    task automatic t_dir();
        run("R4 dir", 4'd1, 8'h64, 8'h99, 16'hFFFF, 16'h0, 16'h1234, 16'h0, 16'h0064, 1'b1);
    endtask

    task automatic t_ext();
        run("R5 ext", 4'd2, 8'h12, 8'h34, 16'h0, 16'h0, 16'h0, 16'h0, 16'h1234, 1'b1);
    endtask

    task automatic t_idx();
        run("R6 idx x", 4'd3, 8'h0A, 8'h00, 16'hA13F, 16'h0, 16'h0, 16'h0, 16'hA149, 1'b1);
        run("R6 idx x unsigned ff", 4'd3, 8'hFF, 8'h00, 16'h1000, 16'h0, 16'h0, 16'h0, 16'h10FF, 1'b1);
        run("R6 idx y wrap", 4'd4, 8'h20, 8'h00, 16'h0, 16'hFFF0, 16'h0, 16'h0, 16'h0010, 1'b1);
    endtask

    task automatic t_ind();
        run("R7 ind x", 4'd5, 8'h55, 8'h66, 16'h1200, 16'h0, 16'h0, 16'h0, 16'h1200, 1'b1);
        run("R7 ind y", 4'd6, 8'h77, 8'h88, 16'h1200, 16'hBEEF, 16'h0, 16'h0, 16'hBEEF, 1'b1);
    endtask

    task automatic t_rel();
        run("R8 rel back", 4'd7, 8'hFE, 8'h00, 16'h0, 16'h0, 16'h1001, 16'h1002, 16'h1000, 1'b1);
        run("R8 rel fwd max", 4'd7, 8'h7F, 8'h00, 16'h0, 16'h0, 16'h0, 16'h2000, 16'h207F, 1'b1);
        run("R8 rel wrap min", 4'd7, 8'h80, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0010, 16'hFF90, 1'b1);
    endtask

    task automatic t_undef();
        run("R9 undef 9", 4'd9, 8'h12, 8'h34, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h0000, 1'b0);
        run("R9 undef 15", 4'd15, 8'hAB, 8'hCD, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h0000, 1'b0);
    endtask

    initial begin
        t_reset();
        t_imm();
        t_dir();
        t_ext();
        t_idx();
        t_ind();
        t_rel();
        t_undef();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule